// File: doc/BRIEF.md
# In-Place Tree Reducer

The block folds a buffer of N unsigned values into one value, either their wrapping sum or their maximum. Software-side logic first fills the buffer through a load port, one element per cycle, at the index it chooses. A start pulse then launches the reduction. The buffer is worked on in place in a register array.

Each step uses a halving stride. It begins at N/2 and halves after every step. In a step, every lane t below the stride folds element t+stride into element t. As a result, the lanes that do work are always a contiguous run starting at index 0. After log2(N) single-cycle steps, element 0 holds the answer. A one-cycle done pulse then presents that answer on the result output, which keeps it until the next completion.

Lanes are grouped into warps of WARP consecutive indices, starting at index 0. While the reduction runs, the block reports how many warps contain at least one working lane in the current step, so that occupancy can be watched step by step.

Top module: `tree_reducer`

## Requirements
- R1: With busy low, a cycle with ld_en high writes ld_data into element ld_idx. The next reduction then uses that value.
- R2: With op_max low, the result is the sum of all N elements modulo 2^DW.
- R3: With op_max high, the result is the unsigned maximum of all N elements.
- R4: Suppose start is sampled high at a clock edge while busy is low. Busy is then high for exactly log2(N) cycles after that edge. On the following cycle busy is low.
- R5: Done is high for exactly one cycle, the first cycle after busy falls, and busy is low in that cycle. Result carries the reduced value in that cycle and keeps it until the next done.
- R6: While busy, active_warps equals ceil(stride/WARP) for the step being executed. The stride is N/2 in the first busy cycle and halves in each later one. While busy is low, active_warps is 0.
- R7: A start pulse sampled while busy is high has no effect. Completion timing and result are those of the run already in progress.
- R8: A load sampled while busy is high is ignored, and the buffer keeps its contents.
- R9: The reduction works in place. In each step, element t (for t below the stride) takes the combination of the old elements t and t+stride. A new start without reloading reduces whatever the previous run left in the buffer.
- R10: The operation is sampled together with start. Changes on op_max during a run do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe for one buffer element |
| ld_idx | input | log2(N) | Element index to load |
| ld_data | input | DW | Value to load |
| op_max | input | 1 | 0 selects sum, 1 selects maximum |
| start | input | 1 | Begins a reduction when idle |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |
| active_warps | output | log2(ceil(N/WARP)+1) | Warps with a working lane in the current step |
| result | output | DW | Reduced value |

## Verification
The assertions assume that reset is held for at least two clock edges before the first operation. They place no limits on start, ld_en or op_max beyond that, because the block must tolerate those inputs in any cycle. The stimulus therefore holds reset for several cycles. It then deliberately drives start, loads and operation changes in the middle of a run, next to directed and random data. This shows that the timing and occupancy properties hold even when these inputs misbehave.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef enum logic {
    OP_SUM = 1'b0,
    OP_MAX = 1'b1
  } tr_op_e;
endpackage

// File: rtl/tr_combine.sv
module tr_combine
  import tr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  tr_op_e        op,
  output logic [DW-1:0] y
);
  always_comb begin
    if (op == OP_MAX) y = (a > b) ? a : b;
    else              y = a + b;
  end
endmodule

// File: rtl/tr_warp_count.sv
module tr_warp_count #(
  parameter int N    = 64,
  parameter int WARP = 32,
  localparam int IW    = $clog2(N),
  localparam int NWARP = (N + WARP - 1) / WARP,
  localparam int CW    = $clog2(NWARP + 1)
) (
  input  logic [IW-1:0] stride,
  output logic [CW-1:0] count
);
  logic [NWARP-1:0] w_act;

  for (genvar w = 0; w < NWARP; w++) begin : g_warp
    assign w_act[w] = (int'(stride) > w * WARP);
  end

  always_comb begin
    count = '0;
    for (int w = 0; w < NWARP; w++) count = count + CW'(w_act[w]);
  end
endmodule

// File: rtl/tr_ctrl.sv
module tr_ctrl #(
  parameter int N = 64,
  localparam int IW   = $clog2(N),
  localparam int HALF = N / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          start_acc,
  output logic          last_step,
  output logic          busy_q,
  output logic          done_q,
  output logic [IW-1:0] stride_q,
  output logic [IW-1:0] stride_d
);
  assign start_acc = start && !busy_q;
  assign last_step = busy_q && (stride_q == IW'(1));

  always_comb begin
    if (start_acc)   stride_d = IW'(HALF);
    else if (busy_q) stride_d = stride_q >> 1;
    else             stride_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      stride_q <= '0;
    end else begin
      stride_q <= stride_d;
      done_q   <= last_step;
      if (start_acc)      busy_q <= 1'b1;
      else if (last_step) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tree_reducer.sv
module tree_reducer
  import tr_pkg::*;
#(
  parameter int N    = 64,
  parameter int DW   = 16,
  parameter int WARP = 32,
  localparam int IW    = $clog2(N),
  localparam int NWARP = (N + WARP - 1) / WARP,
  localparam int CW    = $clog2(NWARP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic          op_max,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] active_warps,
  output logic [DW-1:0] result
);
  localparam int HALF = N / 2;

  logic          start_acc, last_step, busy_q, done_q;
  logic [IW-1:0] stride_q, stride_d;
  logic [CW-1:0] warps_d;
  logic [CW-1:0] warps_q;
  logic [DW-1:0] result_q;
  tr_op_e        op_q;

  logic [DW-1:0] buf_q  [N];
  logic [DW-1:0] lane_y [HALF];

  tr_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_acc (start_acc),
    .last_step (last_step),
    .busy_q    (busy_q),
    .done_q    (done_q),
    .stride_q  (stride_q),
    .stride_d  (stride_d)
  );

  // occupancy of the step that will run in the next cycle
  tr_warp_count #(.N(N), .WARP(WARP)) u_wcnt (
    .stride (stride_d),
    .count  (warps_d)
  );

  for (genvar t = 0; t < HALF; t++) begin : g_lane
    logic [IW-1:0] partner;
    assign partner = IW'(t) + stride_q;
    tr_combine #(.DW(DW)) u_comb (
      .a  (buf_q[t]),
      .b  (buf_q[partner]),
      .op (op_q),
      .y  (lane_y[t])
    );
  end

  always_ff @(posedge clk) begin
    if (!busy_q && ld_en) begin
      buf_q[ld_idx] <= ld_data;
    end else if (busy_q) begin
      for (int t = 0; t < HALF; t++) begin
        if (IW'(t) < stride_q) buf_q[t] <= lane_y[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_SUM;
      warps_q  <= '0;
      result_q <= '0;
    end else begin
      warps_q <= warps_d;
      if (start_acc) op_q <= tr_op_e'(op_max);
      if (last_step) result_q <= lane_y[0];
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign active_warps = warps_q;
  assign result       = result_q;
endmodule

// File: rtl/tree_reducer_chk.sv
module tree_reducer_chk #(
  parameter int N    = 64,
  parameter int WARP = 32,
  parameter int DW   = 16,
  localparam int IW    = $clog2(N),
  localparam int NWARP = (N + WARP - 1) / WARP,
  localparam int CW    = $clog2(NWARP + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] active_warps,
  input logic [DW-1:0] result
);
  localparam int STEPS = $clog2(N);

  logic [IW:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst)                 run_cnt <= '0;
    else if (start && !busy) run_cnt <= '0;
    else if (busy)           run_cnt <= run_cnt + 1'b1;
  end

  p_start_takes_r4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cnt == (IW+1)'(STEPS)));
  p_no_overrun_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_cnt < (IW+1)'(STEPS)));
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
  p_idle_warps_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (active_warps == '0));
  p_warps_shrink_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (active_warps <= $past(active_warps)));
  p_warps_live_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (active_warps != '0));
endmodule

bind tree_reducer tree_reducer_chk #(.N(N), .WARP(WARP), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .active_warps (active_warps),
  .result       (result)
);

// File: tb/tree_reducer_tb.sv
module tree_reducer_tb;
  localparam int N     = 64;
  localparam int DW    = 16;
  localparam int WARP  = 32;
  localparam int IW    = $clog2(N);
  localparam int NWARP = (N + WARP - 1) / WARP;
  localparam int CW    = $clog2(NWARP + 1);
  localparam int STEPS = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_en = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [DW-1:0] ld_data = '0;
  logic          op_max = 1'b0;
  logic          start = 1'b0;
  logic          busy, done;
  logic [CW-1:0] active_warps;
  logic [DW-1:0] result;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [N];

  always #10 clk = ~clk;

  tree_reducer #(.N(N), .DW(DW), .WARP(WARP)) u_dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .op_max(op_max), .start(start), .busy(busy), .done(done),
    .active_warps(active_warps), .result(result)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] fold(input bit m, input logic [DW-1:0] a, input logic [DW-1:0] b);
    if (m) return (a > b) ? a : b;
    return a + b;
  endfunction

  // in-place halving reduction on the bench's own copy of the buffer
  function automatic logic [DW-1:0] model_run(input bit m);
    for (int s = N / 2; s >= 1; s = s / 2)
      for (int t = 0; t < s; t++) model[t] = fold(m, model[t], model[t + s]);
    return model[0];
  endfunction

  function automatic int exp_warps(input int step);
    int s;
    s = (N / 2) >> step;
    return (s + WARP - 1) / WARP;
  endfunction

  task automatic load_one(input int idx, input logic [DW-1:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = IW'(idx); ld_data = v;
    model[idx] = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_all(input int kind);
    for (int i = 0; i < N; i++) begin
      logic [DW-1:0] v;
      case (kind)
        0: v = '1;
        1: v = DW'(i);
        2: v = DW'(i * 3 + 7);
        default: v = DW'($urandom);
      endcase
      @(negedge clk);
      ld_en = 1'b1; ld_idx = IW'(i); ld_data = v;
      model[i] = v;
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // glitch: 0 none, 1 start during run (R7), 2 load during run (R8), 3 op change (R10)
  task automatic run(input bit m, input int glitch);
    logic [DW-1:0] exp;
    string rq;
    exp = model_run(m);
    rq = m ? "R3" : "R2";
    @(negedge clk);
    op_max = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < STEPS; s++) begin
      chk("R4 busy during step", 32'(busy), 32'd1);
      chk("R6 active warps", 32'(active_warps), 32'(exp_warps(s)));
      if (s == 1) begin
        case (glitch)
          1: start = 1'b1;
          2: begin ld_en = 1'b1; ld_idx = '0; ld_data = ~model[0]; end
          3: op_max = ~m;
          default: ;
        endcase
      end
      @(negedge clk);
      start = 1'b0; ld_en = 1'b0;
    end
    chk("R4 busy low at end", 32'(busy), 32'd0);
    chk("R5 done pulse", 32'(done), 32'd1);
    chk(glitch == 1 ? "R7 result" : glitch == 3 ? "R10 result" : rq, 32'(result), 32'(exp));
    @(negedge clk);
    chk("R5 done one cycle", 32'(done), 32'd0);
    chk("R5 result held", 32'(result), 32'(exp));
    chk("R6 idle warps", 32'(active_warps), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset busy", 32'(busy), 32'd0);
    chk("reset done", 32'(done), 32'd0);
    chk("R6 reset warps", 32'(active_warps), 32'd0);
    chk("reset result", 32'(result), 32'd0);

    // R2 wrap: all ones sums to -N modulo 2^DW
    load_all(0);
    run(1'b0, 0);
    chk("R2 wrap value", 32'(result), 32'((1 << DW) - N));
    // R3 on a ramp, maximum in the top element
    load_all(1);
    run(1'b1, 0);
    chk("R3 ramp max", 32'(result), 32'(N - 1));
    // R9 rerun without reload on the in-place residue
    run(1'b0, 0);
    // R1 single element overwrite, then max
    load_all(2);
    load_one(N - 1, 16'hBEEF);
    run(1'b1, 0);
    chk("R1 loaded element wins", 32'(result), 32'hBEEF);
    // R7, R8, R10 disturbances during runs
    load_all(3);
    run(1'b0, 1);
    load_all(3);
    run(1'b1, 2);
    run(1'b0, 2);
    load_all(3);
    run(1'b0, 3);
    load_all(3);
    run(1'b1, 3);
    // random mix, with occasional reruns on the residue (R9)
    for (int k = 0; k < 20; k++) begin
      if (($urandom % 3) != 0) load_all(3);
      run(1'($urandom), int'($urandom % 4));
    end
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule